// File: doc/BRIEF.md
# Serial EEPROM Device Responder

This block is a synthesizable stand-in for a small three-wire serial EEPROM that stores 16-bit words. It serves as a target when testing a serial EEPROM master. The master drives chip select, a serial clock and serial data in, and the responder answers on serial data out. All inputs are sampled on a fast system clock. A rising serial clock is found by comparing the input with its value one system-clock cycle earlier, so the serial clock must stay in each phase for at least two system-clock cycles.

Each frame begins with a start bit, which is the first 1 sampled on a rising serial clock. A two-bit opcode and an address follow. A read returns one dummy zero and then the addressed word. The programming commands are write, erase, erase-all and write-all. They take effect only when chip select drops at the end of a complete frame, and only if the write-enable latch is set. Once such a command has taken effect, a busy period of `BUSY_CYCLES` system clocks follows. During the next chip-select-high period, data out shows the device status.

Top module: `mw_eeprom_resp`

## Requirements
- R1: After reset, the write-enable latch is cleared, every word reads 0xFFFF, and data out is 0, including while chip select is high before any programming command.
- R2: While chip select is high and no frame is in progress, 0 bits on rising serial clock edges are ignored. The first 1 is taken as the start bit.
- R3: A read (opcode 10) is followed by ADDR_W address bits, MSB first. After the last address bit, data out is 0. After each later rising edge it presents the next bit of the word, bit 15 first.
- R4: Opcode 00 takes its meaning from the two most significant address bits: 11 sets the write-enable latch, 00 clears it, 10 is erase-all and 01 is write-all. The remaining address bits are ignored.
- R5: Write, erase, erase-all and write-all leave the array unchanged and produce no status indication while the write-enable latch is cleared.
- R6: A write (opcode 01) takes 16 data bits, MSB first, after the address. The word is stored when chip select falls after the last data bit.
- R7: Erase (opcode 11) sets the addressed word to 0xFFFF and leaves the other words unchanged. Erase-all sets every word to 0xFFFF. Write-all stores its 16 data bits in every word.
- R8: Once a programming command has taken effect, data out reads 0 while chip select is high during the next BUSY_CYCLES system clocks, and 1 after that. Start bits received while busy are ignored.
- R9: If chip select drops before a frame is complete, the partial instruction is discarded: no word changes and no status is shown.
- R10: Data out is 0 while chip select is low, and also while chip select is high in any state other than read output or status display.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all serial inputs |
| rstN | input | 1 | Asynchronous active-low reset |
| csIn | input | 1 | Chip select, active high |
| sclkIn | input | 1 | Serial clock from the master |
| dataIn | input | 1 | Serial data from the master |
| dataOut | output | 1 | Serial data to the master: read data or ready status |

## Verification
The hardest case to reach is a start bit that arrives while the device is still busy. It only exists in the short window between the chip-select fall that commits a programming command and the end of the busy count. The bench raises chip select a few system clocks after each commit, so that data out can be checked while busy. Right after one such commit it clocks a 1 into the responder. It then waits for the end of the busy period and checks that data out reads ready status. Read data or a silent output would mean the start bit had been accepted.

// File: rtl/mw_resp_pkg.sv
package mw_resp_pkg;

  typedef enum logic [1:0] {
    PG_WRITE = 2'd0,
    PG_ERASE = 2'd1,
    PG_ERAL  = 2'd2,
    PG_WRAL  = 2'd3
  } progOp_e;

  // strobes from control to datapath, all valid for one system clock
  typedef struct packed {
    logic    startSeen;
    logic    dataShift;
    logic    dataBit;
    logic    loadRead;
    logic    shiftRead;
    logic    setWel;
    logic    clrWel;
    logic    commit;
    progOp_e op;
  } ctlStrobe_t;

endpackage

// File: rtl/mw_resp_ctrl.sv
module mw_resp_ctrl
  import mw_resp_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csIn,
  input  logic              sclkIn,
  input  logic              dataIn,
  input  logic              busy,
  output ctlStrobe_t        ctl,
  output logic [ADDR_W-1:0] addr,
  output logic              readActive,
  output logic              idleHigh
);
  localparam int HDR_LEN = ADDR_W + 2;
  localparam int CNT_MAX = (HDR_LEN > WORD_W) ? HDR_LEN : WORD_W;
  localparam int CNT_W   = $clog2(CNT_MAX);
  localparam logic [CNT_W-1:0] HDR_LAST  = CNT_W'(HDR_LEN - 1);
  localparam logic [CNT_W-1:0] DATA_LAST = CNT_W'(WORD_W - 1);

  typedef enum logic [2:0] {S_WAIT, S_HDR, S_DATA, S_READ, S_DONE} state_e;

  state_e             state;
  logic               sclkQ, csQ;
  logic [HDR_LEN-2:0] hdr;
  logic [CNT_W-1:0]   cnt;
  logic               pendValid;
  progOp_e            pendOp;

  logic               rise, fall, lastHdr;
  logic [HDR_LEN-1:0] hdrNext;
  logic [1:0]         opBits, subBits;

  assign rise    = csIn & sclkIn & ~sclkQ;
  assign fall    = csQ & ~csIn;
  assign hdrNext = {hdr, dataIn};
  assign opBits  = hdrNext[HDR_LEN-1 -: 2];
  assign subBits = hdrNext[ADDR_W-1 -: 2];
  assign lastHdr = rise && (state == S_HDR) && (cnt == HDR_LAST);

  always_comb begin
    ctl           = '0;
    ctl.startSeen = rise && (state == S_WAIT) && dataIn && !busy;
    ctl.dataShift = rise && (state == S_DATA);
    ctl.dataBit   = dataIn;
    ctl.shiftRead = rise && (state == S_READ);
    ctl.loadRead  = lastHdr && (opBits == 2'b10);
    ctl.setWel    = lastHdr && (opBits == 2'b00) && (subBits == 2'b11);
    ctl.clrWel    = lastHdr && (opBits == 2'b00) && (subBits == 2'b00);
    ctl.commit    = fall && pendValid;
    ctl.op        = pendOp;
  end

  assign addr       = (state == S_HDR) ? hdrNext[ADDR_W-1:0] : hdr[ADDR_W-1:0];
  assign readActive = csIn && (state == S_READ);
  assign idleHigh   = csIn && (state == S_WAIT);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= S_WAIT;
      sclkQ     <= 1'b0;
      csQ       <= 1'b0;
      hdr       <= '0;
      cnt       <= '0;
      pendValid <= 1'b0;
      pendOp    <= PG_WRITE;
    end else begin
      sclkQ <= sclkIn;
      csQ   <= csIn;
      if (!csIn) begin
        state     <= S_WAIT;
        cnt       <= '0;
        pendValid <= 1'b0;
      end else begin
        case (state)
          S_WAIT: if (ctl.startSeen) begin
            state <= S_HDR;
            cnt   <= '0;
          end
          S_HDR: if (rise) begin
            hdr <= hdrNext[HDR_LEN-2:0];
            cnt <= cnt + 1'b1;
            if (cnt == HDR_LAST) begin
              cnt <= '0;
              case (opBits)
                2'b10: state <= S_READ;
                2'b01: begin state <= S_DATA; pendOp <= PG_WRITE; end
                2'b11: begin state <= S_DONE; pendOp <= PG_ERASE; pendValid <= 1'b1; end
                default: begin
                  case (subBits)
                    2'b10:   begin state <= S_DONE; pendOp <= PG_ERAL; pendValid <= 1'b1; end
                    2'b01:   begin state <= S_DATA; pendOp <= PG_WRAL; end
                    default: state <= S_DONE;
                  endcase
                end
              endcase
            end
          end
          S_DATA: if (rise) begin
            cnt <= cnt + 1'b1;
            if (cnt == DATA_LAST) begin
              state     <= S_DONE;
              pendValid <= 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/mw_resp_dpath.sv
module mw_resp_dpath
  import mw_resp_pkg::*;
#(
  parameter int ADDR_W      = 6,
  parameter int WORD_W      = 16,
  parameter int BUSY_CYCLES = 24
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        ctl,
  input  logic [ADDR_W-1:0] addr,
  input  logic              readActive,
  input  logic              idleHigh,
  output logic              dataOut,
  output logic              busy,
  output logic              wel
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int BW    = $clog2(BUSY_CYCLES + 1);

  logic [WORD_W-1:0] mem [DEPTH];
  logic [WORD_W-1:0] dataSr;
  logic [WORD_W:0]   outSr;
  logic [BW-1:0]     busyCnt;
  logic              statusArmed;
  logic              progOk;

  assign progOk = ctl.commit && wel;
  assign busy   = (busyCnt != '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int w = 0; w < DEPTH; w++) mem[w] <= '1;
    end else if (progOk) begin
      for (int w = 0; w < DEPTH; w++) begin
        case (ctl.op)
          PG_WRITE: if (addr == ADDR_W'(w)) mem[w] <= dataSr;
          PG_ERASE: if (addr == ADDR_W'(w)) mem[w] <= '1;
          PG_ERAL:  mem[w] <= '1;
          default:  mem[w] <= dataSr;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataSr      <= '0;
      outSr       <= '0;
      busyCnt     <= '0;
      statusArmed <= 1'b0;
      wel         <= 1'b0;
    end else begin
      if (ctl.dataShift) dataSr <= {dataSr[WORD_W-2:0], ctl.dataBit};
      if (ctl.loadRead)       outSr <= {1'b0, mem[addr]};
      else if (ctl.shiftRead) outSr <= {outSr[WORD_W-1:0], 1'b0};
      if (progOk)    busyCnt <= BW'(BUSY_CYCLES);
      else if (busy) busyCnt <= busyCnt - 1'b1;
      if (progOk)             statusArmed <= 1'b1;
      else if (ctl.startSeen) statusArmed <= 1'b0;
      if (ctl.setWel)      wel <= 1'b1;
      else if (ctl.clrWel) wel <= 1'b0;
    end
  end

  always_comb begin
    if (readActive)                    dataOut = outSr[WORD_W];
    else if (idleHigh && statusArmed)  dataOut = !busy;
    else                               dataOut = 1'b0;
  end
endmodule

// File: rtl/mw_eeprom_resp.sv
module mw_eeprom_resp
  import mw_resp_pkg::*;
#(
  parameter int ADDR_W      = 6,
  parameter int WORD_W      = 16,
  parameter int BUSY_CYCLES = 24
) (
  input  logic clk,
  input  logic rstN,
  input  logic csIn,
  input  logic sclkIn,
  input  logic dataIn,
  output logic dataOut
);
  ctlStrobe_t        ctl;
  logic [ADDR_W-1:0] addr;
  logic              readActive, idleHigh, busy, wel;

  mw_resp_ctrl #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .csIn(csIn), .sclkIn(sclkIn), .dataIn(dataIn),
    .busy(busy), .ctl(ctl), .addr(addr), .readActive(readActive), .idleHigh(idleHigh)
  );

  mw_resp_dpath #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .BUSY_CYCLES(BUSY_CYCLES)) i_dpath (
    .clk(clk), .rstN(rstN), .ctl(ctl), .addr(addr), .readActive(readActive),
    .idleHigh(idleHigh), .dataOut(dataOut), .busy(busy), .wel(wel)
  );
endmodule

// File: rtl/mw_resp_checker.sv
module mw_resp_checker
  import mw_resp_pkg::*;
(
  input logic       clk,
  input logic       rstN,
  input logic       csIn,
  input logic       dataOut,
  input logic       busy,
  input logic       wel,
  input ctlStrobe_t ctl
);
  // R10: nothing is driven while deselected
  a_r10_quiet_deselected: assert property (@(posedge clk) disable iff (!rstN)
    !csIn |-> !dataOut);

  // R5: a locked commit starts no busy period
  a_r5_locked_no_busy: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.commit && !wel) |=> !busy);

  // R8: an enabled commit starts the busy period (BUSY_CYCLES >= 1)
  a_r8_busy_after_commit: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.commit && wel) |=> busy);

  // R4: enable and disable subcodes reach the latch
  a_r4_enable_sets: assert property (@(posedge clk) disable iff (!rstN)
    ctl.setWel |=> wel);
  a_r4_disable_clears: assert property (@(posedge clk) disable iff (!rstN)
    ctl.clrWel |=> !wel);
endmodule

bind mw_eeprom_resp mw_resp_checker i_checker (
  .clk(clk), .rstN(rstN), .csIn(csIn), .dataOut(dataOut),
  .busy(busy), .wel(wel), .ctl(ctl)
);

// File: tb/test_mw_eeprom_resp.sv
module test_mw_eeprom_resp;
  localparam int ADDR_W = 6;
  localparam int BUSY   = 24;

  logic clk = 1'b0, rstN = 1'b0, csIn = 1'b0, sclkIn = 1'b0, dataIn = 1'b0;
  wire  dataOut;
  int   tests = 0, fails = 0;
  bit   done = 1'b0;

  always #10 clk = ~clk;

  mw_eeprom_resp #(.ADDR_W(ADDR_W), .WORD_W(16), .BUSY_CYCLES(BUSY)) i_mw_eeprom_resp (
    .clk(clk), .rstN(rstN), .csIn(csIn), .sclkIn(sclkIn), .dataIn(dataIn), .dataOut(dataOut)
  );

  function automatic logic [15:0] pat(input int a);
    return 16'((a * 16'h0B3D) ^ 16'hA55A);
  endfunction

  task automatic chk(input string tag, input logic [16:0] act, input logic [16:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one serial bit: sample data out before the rising edge
  task automatic tick(input logic b, output logic o);
    dataIn = b;
    repeat (3) @(negedge clk);
    o = dataOut;
    sclkIn = 1'b1;
    repeat (3) @(negedge clk);
    sclkIn = 1'b0;
  endtask

  task automatic send(input logic [15:0] v, input int n, output logic anyHigh);
    logic o;
    anyHigh = 1'b0;
    for (int i = n - 1; i >= 0; i--) begin
      tick(v[i], o);
      anyHigh = anyHigh | o;
    end
  endtask

  task automatic frameStart();
    csIn = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic frameEnd();
    sclkIn = 1'b0;
    csIn   = 1'b0;
    dataIn = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic readWord(input int a, input int lead, output logic [15:0] val, output logic dummy);
    logic o, h;
    frameStart();
    send(16'h0, lead, h);
    send(16'b110, 3, h);
    send(16'(a), ADDR_W, h);
    for (int i = 0; i < 17; i++) begin
      tick(1'b0, o);
      if (i == 0) dummy = o;
      else val[16-i] = o;
    end
    frameEnd();
  endtask

  task automatic progFrame(input logic [1:0] op, input int a, input bit withData,
                           input logic [15:0] d, input int lead, output logic anyHigh);
    logic h1, h2;
    frameStart();
    send(16'h0, lead, h1);
    send(16'h1, 1, h1);
    send(16'(op), 2, anyHigh);
    send(16'(a), ADDR_W, h2);
    anyHigh = anyHigh | h2;
    if (withData) begin
      send(d, 16, h2);
      anyHigh = anyHigh | h2;
    end
    frameEnd();
  endtask

  task automatic checkStatus(input string tag);
    frameStart();
    chk({tag, " busy"}, {16'h0, dataOut}, 17'h0);
    repeat (BUSY + 4) @(negedge clk);
    chk({tag, " ready"}, {16'h0, dataOut}, 17'h1);
    frameEnd();
  endtask

  task automatic checkSilent(input string tag);
    frameStart();
    repeat (BUSY + 4) @(negedge clk);
    chk(tag, {16'h0, dataOut}, 17'h0);
    frameEnd();
  endtask

  task automatic expectWord(input string tag, input int a, input logic [15:0] exp);
    logic [15:0] v;
    logic dm;
    readWord(a, a % 3, v, dm);
    chk({tag, " dummy R3"}, {16'h0, dm}, 17'h0);
    chk(tag, {1'b0, v}, {1'b0, exp});
  endtask

  initial begin
    repeat (100000) @(negedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic h;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 idle output", {16'h0, dataOut}, 17'h0);
    checkSilent("R1 no status after reset");
    for (int a = 0; a < 64; a++) expectWord("R1 erased after reset", a, 16'hFFFF);

    // R5: write without the latch
    progFrame(2'b01, 5, 1'b1, 16'h1234, 0, h);
    checkSilent("R5 locked write shows no status");
    expectWord("R5 locked write ignored", 5, 16'hFFFF);

    // R4: enable (subcode 11)
    progFrame(2'b00, 6'b110000, 1'b0, 16'h0, 2, h);
    checkSilent("R4 enable is not programming");

    // R6 sweep with leading zeros (R2) and status (R8)
    for (int a = 0; a < 64; a++) begin
      progFrame(2'b01, a, 1'b1, pat(a), a % 4, h);
      chk("R10 quiet during write frame", {16'h0, h}, 17'h0);
      checkStatus("R8 write status");
    end
    for (int a = 0; a < 64; a++) expectWord("R6 write readback R2", a, pat(a));

    // R8: start bit while busy is ignored
    progFrame(2'b01, 10, 1'b1, 16'h0F0F, 0, h);
    frameStart();
    tick(1'b1, h);
    tick(1'b0, h);
    repeat (BUSY + 4) @(negedge clk);
    chk("R8 start ignored while busy", {16'h0, dataOut}, 17'h1);
    frameEnd();
    expectWord("R8 write under test", 10, 16'h0F0F);

    // R9: abort a write after 8 data bits
    frameStart();
    send(16'b101, 3, h);
    send(16'd9, ADDR_W, h);
    send(16'h00AA, 8, h);
    frameEnd();
    checkSilent("R9 aborted frame shows no status");
    expectWord("R9 aborted write", 9, pat(9));

    // R7: single erase
    progFrame(2'b11, 7, 1'b0, 16'h0, 1, h);
    checkStatus("R7 erase status");
    expectWord("R7 erased word", 7, 16'hFFFF);
    expectWord("R7 neighbour kept", 8, pat(8));

    // R7: write-all (subcode 01)
    progFrame(2'b00, 6'b010000, 1'b1, 16'hC3A5, 0, h);
    checkStatus("R7 write-all status");
    expectWord("R7 write-all low", 0, 16'hC3A5);
    expectWord("R7 write-all mid", 33, 16'hC3A5);
    expectWord("R7 write-all high", 63, 16'hC3A5);

    // R4/R5: disable (subcode 00), then programming is locked
    progFrame(2'b00, 6'b000000, 1'b0, 16'h0, 0, h);
    progFrame(2'b11, 3, 1'b0, 16'h0, 0, h);
    checkSilent("R5 locked erase shows no status");
    expectWord("R4 disable locks erase R5", 3, 16'hC3A5);
    progFrame(2'b00, 6'b100000, 1'b0, 16'h0, 0, h);
    expectWord("R5 locked erase-all", 40, 16'hC3A5);

    // R7: erase-all (subcode 10) after enabling again
    progFrame(2'b00, 6'b111111, 1'b0, 16'h0, 0, h);
    progFrame(2'b00, 6'b101010, 1'b0, 16'h0, 0, h);
    checkStatus("R7 erase-all status");
    for (int a = 0; a < 64; a++) expectWord("R7 erase-all", a, 16'hFFFF);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule